// File: doc/BRIEF.md
# Five-Operation Accumulator Processor

This block is a very small 8-bit processor. Program and data share one 16-byte RAM. Software fills the RAM through a byte write port while the core is held in reset. When reset is released, the core fetches and runs one instruction at a time, starting at address 0.

Each instruction byte carries a 4-bit operation code and a 4-bit memory address. The core has an accumulator, a holding register for the memory operand and a visible output register. Arithmetic runs through a single ripple adder. For subtraction, the memory operand is inverted and the carry-in is forced high.

The program counter can only count upward. There is no branch, no flag, no stack and no input port. The only visible results are the output register and a halted indicator.

Top module: `tiny_acc_cpu`

## Requirements
- R1: With `rst_n` low and `load_en` high, a rising clock edge stores `load_data` at RAM address `load_addr`. With `rst_n` high, `load_en` is ignored and the RAM keeps its contents.
- R2: While `rst_n` is low, `out_value` reads 0 and `halted` reads 0. After `rst_n` rises, execution begins at address 0. Reset leaves the RAM contents unchanged.
- R3: An instruction byte holds the operation code in bits 7:4 and an operand address in bits 3:0. Code 0x0 loads the accumulator from RAM at that address.
- R4: Code 0x1 adds the addressed RAM byte to the accumulator, modulo 256.
- R5: Code 0x2 subtracts the addressed RAM byte from the accumulator in two's complement, modulo 256.
- R6: Code 0xE copies the accumulator to `out_value`. Counting rising edges after reset release from 1, instruction k (0-based) updates `out_value` on edge 6k+4. `out_value` changes on no other edge.
- R7: Code 0xF raises `halted` on edge 6k+4 of its slot. From then on `halted` stays high and `out_value` stays frozen until the next reset.
- R8: Every instruction takes exactly six clock cycles. The program counter steps by one per instruction and wraps from 15 to 0, so execution continues through the whole RAM and starts again at address 0.
- R9: Operation codes 0x3 to 0xD do nothing. They leave the accumulator and `out_value` unchanged and use their six cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; RAM loading is allowed only while it is low |
| load_en | input | 1 | RAM write strobe for program loading |
| load_addr | input | 4 | RAM address for the load write |
| load_data | input | 8 | Byte to store at `load_addr` |
| out_value | output | 8 | Output register, written by the output operation |
| halted | output | 1 | High once the halt operation has executed |

## Verification
Only two things are visible at the ports: `out_value` and `halted`. A corrupted program counter, instruction register or timing-state ring therefore shows up as a wrong value, or a value on the wrong edge, the next time an output or halt instruction reaches its fourth cycle. That is at most one instruction slot later for a timing fault, and possibly many slots later for a wrong accumulator. A cycle-by-cycle model in the bench compares both outputs after every edge, so a slot error is reported on the edge where it first becomes visible. A bad adder or operand fetch appears as a wrong value at the next output instruction. A missed wrap appears after sixteen instruction slots, when the output instruction at address 2 should run a second time.

// File: rtl/tiny_acc_pkg.sv
package tiny_acc_pkg;

   localparam int OPC_W = 4;
   localparam int NPH   = 6;

   // timing-state indices within one instruction slot
   localparam int PH_ADDR = 0;
   localparam int PH_READ = 1;
   localparam int PH_INC  = 2;
   localparam int PH_EX1  = 3;
   localparam int PH_EX2  = 4;
   localparam int PH_EX3  = 5;

   typedef enum logic [OPC_W-1:0] {
      OP_LDA = 4'h0,
      OP_ADD = 4'h1,
      OP_SUB = 4'h2,
      OP_OUT = 4'hE,
      OP_HLT = 4'hF
   } opcode_e;

endpackage

// File: rtl/tiny_acc_ram.sv
module tiny_acc_ram #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("tiny_acc_ram: AW out of range");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/tiny_acc_seq.sv
module tiny_acc_seq #(
   parameter int NPH = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   output logic [NPH-1:0] phase
);

   localparam logic [NPH-1:0] FIRST = {{(NPH-1){1'b0}}, 1'b1};

   if (NPH < 2) begin : g_bad_nph
      $error("tiny_acc_seq: NPH must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= FIRST;
      end else if (run) begin
         phase <= {phase[NPH-2:0], phase[NPH-1]};
      end
   end

endmodule

// File: rtl/tiny_acc_alu.sv
module tiny_acc_alu #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y
);

   logic [W-1:0] bx;
   assign bx = b ^ {W{sub}};

   if (W < 2) begin : g_bad_w
      $error("tiny_acc_alu: W must be at least 2");
   end

   if (RIPPLE) begin : g_ripple
      logic [W-1:0] c;
      assign c[0] = sub;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign y[i] = a[i] ^ bx[i] ^ c[i];
         if (i < W - 1) begin : g_carry
            assign c[i+1] = (a[i] & bx[i]) | (c[i] & (a[i] ^ bx[i]));
         end
      end
   end else begin : g_flat
      assign y = a + bx + {{(W-1){1'b0}}, sub};
   end

endmodule

// File: rtl/tiny_acc_cpu.sv
module tiny_acc_cpu
   import tiny_acc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_data,
   output logic [DATA_W-1:0] out_value,
   output logic              halted
);

   localparam logic [ADDR_W-1:0] PC_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   if (DATA_W != ADDR_W + OPC_W) begin : g_bad_fmt
      $error("tiny_acc_cpu: DATA_W must equal ADDR_W plus the opcode width");
   end

   logic [NPH-1:0]    phase;
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] mar_q;
   logic [DATA_W-1:0] ir_q;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] breg_q;
   logic [DATA_W-1:0] out_q;
   logic              halt_q;
   logic [DATA_W-1:0] ram_rdata;
   logic [DATA_W-1:0] alu_y;
   opcode_e           opc;
   logic              is_lda, is_add, is_sub, is_out, is_hlt, uses_mem;

   tiny_acc_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
      .clk   (clk),
      .we    (load_en & ~rst_n),
      .waddr (load_addr),
      .wdata (load_data),
      .raddr (mar_q),
      .rdata (ram_rdata)
   );

   tiny_acc_seq #(.NPH(NPH)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (~halt_q),
      .phase (phase)
   );

   tiny_acc_alu #(.W(DATA_W), .RIPPLE(RIPPLE)) u_alu (
      .a   (acc_q),
      .b   (breg_q),
      .sub (is_sub),
      .y   (alu_y)
   );

   assign opc = opcode_e'(ir_q[DATA_W-1 -: OPC_W]);

   always_comb begin
      is_lda   = (opc == OP_LDA);
      is_add   = (opc == OP_ADD);
      is_sub   = (opc == OP_SUB);
      is_out   = (opc == OP_OUT);
      is_hlt   = (opc == OP_HLT);
      uses_mem = is_lda | is_add | is_sub;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         mar_q  <= '0;
         ir_q   <= '0;
         acc_q  <= '0;
         breg_q <= '0;
         out_q  <= '0;
         halt_q <= 1'b0;
      end else if (!halt_q) begin
         if (phase[PH_ADDR]) begin
            mar_q <= pc_q;
         end
         if (phase[PH_READ]) begin
            ir_q <= ram_rdata;
         end
         if (phase[PH_INC]) begin
            pc_q <= pc_q + PC_ONE;
         end
         if (phase[PH_EX1]) begin
            if (uses_mem) begin
               mar_q <= ir_q[ADDR_W-1:0];
            end
            if (is_out) begin
               out_q <= acc_q;
            end
            if (is_hlt) begin
               halt_q <= 1'b1;
            end
         end
         if (phase[PH_EX2]) begin
            if (is_lda) begin
               acc_q <= ram_rdata;
            end
            if (is_add | is_sub) begin
               breg_q <= ram_rdata;
            end
         end
         if (phase[PH_EX3]) begin
            if (is_add | is_sub) begin
               acc_q <= alu_y;
            end
         end
      end
   end

   assign out_value = out_q;
   assign halted    = halt_q;

endmodule

// File: rtl/tiny_acc_cpu_chk.sv
module tiny_acc_cpu_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int NPH    = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] out_value,
   input logic              halted,
   input logic [ADDR_W-1:0] pc,
   input logic [NPH-1:0]    phase
);

   localparam int EX2 = 4;

   // R2
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_clear_chk: assert (out_value == '0 && !halted)
            else $error("outputs not cleared in reset");
      end
   end

   // R7
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R7
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(out_value));

   // R7
   halt_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> phase[EX2]);

   // R6
   out_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_value) |-> phase[EX2]);

   // R8
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pc) |-> pc == ADDR_W'($past(pc) + 1'b1));

   // R8
   phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phase) == 1);

   // R8
   phase_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !halted |=> phase == {$past(phase[NPH-2:0]), $past(phase[NPH-1])});

endmodule

bind tiny_acc_cpu tiny_acc_cpu_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .NPH    (tiny_acc_pkg::NPH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_value (out_value),
   .halted    (halted),
   .pc        (pc_q),
   .phase     (phase)
);

// File: tb/tiny_acc_cpu_bench.sv
`timescale 1ns/1ps
module tiny_acc_cpu_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       load_en = 1'b0;
   logic [3:0] load_addr = '0;
   logic [7:0] load_data = '0;
   logic [7:0] out_value;
   logic       halted;

   int n_chk = 0;
   int n_fail = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tiny_acc_cpu u_tiny_acc_cpu (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .load_addr (load_addr),
      .load_data (load_data),
      .out_value (out_value),
      .halted    (halted)
   );

   // behavioural reference model
   logic [7:0] m_mem [16];
   int         m_ph;
   logic [3:0] m_pc;
   logic [7:0] m_ir, m_acc, m_out;
   bit         m_halt;

   always @(posedge clk) begin
      if (!rst_n && load_en) m_mem[load_addr] <= load_data;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_pc = 0; m_ir = 0; m_acc = 0; m_out = 0; m_halt = 0;
      end else if (!m_halt) begin
         if (m_ph == 1) m_ir = m_mem[m_pc];
         if (m_ph == 2) m_pc = m_pc + 4'd1;
         if (m_ph == 3) begin
            case (m_ir[7:4])
               4'h0: m_acc = m_mem[m_ir[3:0]];
               4'h1: m_acc = m_acc + m_mem[m_ir[3:0]];
               4'h2: m_acc = m_acc - m_mem[m_ir[3:0]];
               4'hE: m_out = m_acc;
               4'hF: m_halt = 1;
               default: ;
            endcase
         end
         m_ph = (m_ph + 1) % 6;
      end
   end

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (cmp_en) begin
         #1;
         chk("R6 per-cycle out_value", out_value, m_out);
         chk("R7 per-cycle halted", {7'b0, halted}, {7'b0, m_halt});
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic load_prog(input logic [7:0] img [16]);
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         load_en = 1'b1;
         load_addr = 4'(i);
         load_data = img[i];
      end
      @(negedge clk);
      load_en = 1'b0;
   endtask

   logic [7:0] prog_a [16];
   logic [7:0] prog_b [16];

   initial begin
      prog_a = '{8'h09, 8'h1A, 8'hE0, 8'h2B, 8'hE0, 8'h1C, 8'hE0, 8'hF0,
                 8'hE0, 8'h28, 8'h0E, 8'h40, 8'hF5, 8'h00, 8'h00, 8'h00};
      prog_b = '{8'h0F, 8'h1E, 8'hE0, 8'h30, 8'h1E, 8'hE0, 8'h35, 8'h4F,
                 8'h5A, 8'h6C, 8'h7E, 8'h80, 8'hB1, 8'hD2, 8'h05, 8'h03};

      #1 rst_n = 1'b0;
      load_prog(prog_a);
      chk("R2 reset out_value", out_value, 8'h00);
      chk("R2 reset halted", {7'b0, halted}, 8'h00);
      cmp_en = 1'b1;

      @(negedge clk);
      rst_n = 1'b1;
      // R1: write attempt while running must be ignored (would zero addr C)
      load_en = 1'b1; load_addr = 4'hC; load_data = 8'h00;
      step(15);
      chk("R6 no update before edge 16", out_value, 8'h00);
      step(1);
      chk("R3 R4 load then add visible at edge 16", out_value, 8'h36);
      load_en = 1'b0;
      step(12);
      chk("R5 subtract with borrow", out_value, 8'hF6);
      step(12);
      chk("R1 run-time write ignored, R4 add wraps", out_value, 8'hEB);
      step(5);
      chk("R7 not halted before edge 46", {7'b0, halted}, 8'h00);
      step(1);
      chk("R7 halted at edge 46", {7'b0, halted}, 8'h01);
      step(30);
      chk("R7 halt persists", {7'b0, halted}, 8'h01);
      chk("R7 out frozen after halt", out_value, 8'hEB);

      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R2 async reset clears out_value", out_value, 8'h00);
      chk("R2 async reset clears halted", {7'b0, halted}, 8'h00);
      load_prog(prog_b);
      @(negedge clk);
      rst_n = 1'b1;
      step(16);
      chk("R2 restart at address 0", out_value, 8'h08);
      step(18);
      chk("R4 second output", out_value, 8'h0D);
      step(60);
      chk("R9 undefined opcodes leave out_value", out_value, 8'h0D);
      chk("R9 no halt from undefined opcodes", {7'b0, halted}, 8'h00);
      step(18);
      chk("R8 pc wrap reruns address 2", out_value, 8'h08);

      cmp_en = 1'b0;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule